// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a parameterised content-addressable store. Software-side control writes words into numbered entries, each with a valid flag. A search presents one key to every entry at once. A mask states which bit positions take part, so any sub-field of the stored word can act as the key. Each entry has its own comparator, which raises one flag when the entry matches. A separate gathering stage registers all flags, then reduces them to a hit bit, a multiple-hit bit and the index of the lowest matching entry. It also returns the full flag vector.

The key and the mask sit in two registers, and each has its own load strobe. Loaded values persist from one search to the next. A search is started by a one-cycle request and completes two clock edges later with a one-cycle done pulse. Requests may be issued on every cycle.

Top module: `masked_cam_search`

## Requirements
- R1: While reset is asserted, and until the first search completes, srch_done, srch_hit, srch_multi, srch_index and srch_vector are all zero; reset clears every entry's valid flag, so a search with a fully ignoring mask then misses.
- R2: With a mask of all zeros, entry e matches exactly when it is valid and its stored word equals the key; bit e of srch_vector reports entry e.
- R3: A mask bit of 1 removes that bit position from the comparison (it always counts as equal); a mask bit of 0 makes it take part. An all-ones mask matches every valid entry.
- R4: An entry whose last write had wr_valid = 0, or that has not been written since reset, never matches.
- R5: When one or more entries match, srch_hit is 1 and srch_index is the lowest matching index. srch_multi is 1 exactly when two or more entries match.
- R6: When no entry matches, srch_hit, srch_multi, srch_index and srch_vector are all zero.
- R7: A request sampled at clock edge k yields srch_done high for exactly the cycle between edges k+1 and k+2, with that search's results. Requests on consecutive cycles each produce their own done pulse, in order.
- R8: A write issued in the same cycle as a search request takes effect after that search: the search sees the old contents and the old valid flag.
- R9: A key or mask load in the same cycle as a request is used by that search. A loaded value is retained and used by later searches that load nothing.
- R10: srch_hit, srch_multi, srch_index and srch_vector change only on the edge that raises srch_done, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDXW | Entry to write |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Valid flag stored with the word (0 invalidates) |
| cmp_load | input | 1 | Load the key register |
| cmp_value | input | WIDTH | New key value |
| mask_load | input | 1 | Load the mask register |
| mask_value | input | WIDTH | New mask value (1 = ignore bit) |
| srch_req | input | 1 | Start a search |
| srch_done | output | 1 | One-cycle completion pulse |
| srch_hit | output | 1 | At least one entry matched |
| srch_multi | output | 1 | Two or more entries matched |
| srch_index | output | IDXW | Lowest matching entry, zero on a miss |
| srch_vector | output | ENTRIES | Per-entry match flags |

## Verification
A corrupted stored word or valid flag appears as a wrong bit in srch_vector on the very next search that covers that entry. Its hit, index and multiple-hit outputs then disagree with the scoreboard two edges after the request. A fault in the flag stage or the encoder shows up in the same done cycle, as an index that is not the lowest set bit of the vector or a multi flag that does not fit the vector's population. A pipeline valid that is lost or duplicated is caught as a missing, early or extra done pulse, and as result outputs that move outside done cycles.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int unsigned CAM_ENTRIES_DEFAULT = 64;
  localparam int unsigned CAM_WIDTH_DEFAULT   = 32;

  // Width of an index that can name n entries; never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cam_key_regs.sv
// Key and mask registers with same-cycle forwarding to the compare logic.
module cam_key_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_load,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic             mask_load,
  input  logic [WIDTH-1:0] mask_value,
  output logic [WIDTH-1:0] key_eff,
  output logic [WIDTH-1:0] ign_eff
);

  logic [WIDTH-1:0] key_q, key_d;
  logic [WIDTH-1:0] ign_q, ign_d;

  always_comb begin
    key_d = key_q;
    ign_d = ign_q;
    if (cmp_load)  key_d = cmp_value;
    if (mask_load) ign_d = mask_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      ign_q <= '0;
    end else begin
      if (cmp_load)  key_q <= key_d;
      if (mask_load) ign_q <= ign_d;
    end
  end

  // The search launched this cycle uses the value loaded this cycle.
  assign key_eff = key_d;
  assign ign_eff = ign_d;

endmodule

// File: rtl/cam_entry_array.sv
// Entry storage with one masked comparator per entry.
module cam_entry_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned IDXW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               wr_valid,
  input  logic [WIDTH-1:0]   key,
  input  logic [WIDTH-1:0]   ign,
  output logic [ENTRIES-1:0] match
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             sel;
    logic [WIDTH-1:0] word_q, word_d;
    logic             vld_q, vld_d;
    logic [WIDTH-1:0] diff;

    assign sel = wr_en && (wr_idx == IDXW'(e));

    always_comb begin
      word_d = word_q;
      vld_d  = vld_q;
      if (sel) begin
        word_d = wr_data;
        vld_d  = wr_valid;
      end
    end

    // Stored words carry no reset; the valid flag guards them.
    always_ff @(posedge clk) begin
      if (sel) word_q <= word_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (sel) vld_q <= vld_d;
    end

    assign diff     = (word_q ^ key) & ~ign;
    assign match[e] = vld_q & ~(|diff);
  end

endmodule

// File: rtl/cam_prio_enc.sv
// Lowest-index priority encoder with any and multiple-hit outputs.
module cam_prio_enc #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDXW    = 6
) (
  input  logic [ENTRIES-1:0] flags,
  output logic               any,
  output logic               multi,
  output logic [IDXW-1:0]    index
);

  logic [ENTRIES-1:0] rest;

  always_comb begin
    index = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (flags[i]) index = IDXW'(i);
    end
  end

  // Clearing the lowest set bit leaves something only if two or more were set.
  assign rest  = flags & (flags - ENTRIES'(1));
  assign any   = |flags;
  assign multi = |rest;

endmodule

// File: rtl/cam_gather.sv
// Two-stage result path: flag capture, then encode and result registers.
module cam_gather #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDXW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [ENTRIES-1:0] match,
  output logic               s1_vld,
  output logic               done,
  output logic               hit,
  output logic               multi,
  output logic [IDXW-1:0]    index,
  output logic [ENTRIES-1:0] vector
);

  logic [ENTRIES-1:0] flags_q, flags_d;
  logic               s1_q;
  logic               enc_any, enc_multi;
  logic [IDXW-1:0]    enc_idx;
  logic               hit_d, multi_d;
  logic [IDXW-1:0]    index_d;
  logic [ENTRIES-1:0] vector_d;

  always_comb begin
    flags_d = req ? match : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      s1_q    <= 1'b0;
    end else begin
      s1_q <= req;
      if (req) flags_q <= flags_d;
    end
  end

  cam_prio_enc #(.ENTRIES(ENTRIES), .IDXW(IDXW)) i_enc (
    .flags (flags_q),
    .any   (enc_any),
    .multi (enc_multi),
    .index (enc_idx)
  );

  always_comb begin
    hit_d    = hit;
    multi_d  = multi;
    index_d  = index;
    vector_d = vector;
    if (s1_q) begin
      hit_d    = enc_any;
      multi_d  = enc_multi;
      index_d  = enc_idx;
      vector_d = flags_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      hit    <= 1'b0;
      multi  <= 1'b0;
      index  <= '0;
      vector <= '0;
    end else begin
      done <= s1_q;
      if (s1_q) begin
        hit    <= hit_d;
        multi  <= multi_d;
        index  <= index_d;
        vector <= vector_d;
      end
    end
  end

  assign s1_vld = s1_q;

endmodule

// File: rtl/masked_cam_search.sv
// Top: masked associative search memory.
module masked_cam_search
  import cam_pkg::*;
#(
  parameter  int unsigned ENTRIES = CAM_ENTRIES_DEFAULT,
  parameter  int unsigned WIDTH   = CAM_WIDTH_DEFAULT,
  localparam int unsigned IDXW    = idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               wr_valid,
  input  logic               cmp_load,
  input  logic [WIDTH-1:0]   cmp_value,
  input  logic               mask_load,
  input  logic [WIDTH-1:0]   mask_value,
  input  logic               srch_req,
  output logic               srch_done,
  output logic               srch_hit,
  output logic               srch_multi,
  output logic [IDXW-1:0]    srch_index,
  output logic [ENTRIES-1:0] srch_vector
);

  logic [WIDTH-1:0]   key_eff;
  logic [WIDTH-1:0]   ign_eff;
  logic [ENTRIES-1:0] match;
  logic               s1_vld;

  cam_key_regs #(.WIDTH(WIDTH)) i_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_load   (cmp_load),
    .cmp_value  (cmp_value),
    .mask_load  (mask_load),
    .mask_value (mask_value),
    .key_eff    (key_eff),
    .ign_eff    (ign_eff)
  );

  cam_entry_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDXW(IDXW)) i_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .key      (key_eff),
    .ign      (ign_eff),
    .match    (match)
  );

  cam_gather #(.ENTRIES(ENTRIES), .IDXW(IDXW)) i_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (srch_req),
    .match  (match),
    .s1_vld (s1_vld),
    .done   (srch_done),
    .hit    (srch_hit),
    .multi  (srch_multi),
    .index  (srch_index),
    .vector (srch_vector)
  );

endmodule

// File: rtl/masked_cam_search_chk.sv
// Protocol and result-consistency checks, bound to the top module.
module masked_cam_search_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDXW    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_req,
  input logic               s1_vld,
  input logic               srch_done,
  input logic               srch_hit,
  input logic               srch_multi,
  input logic [IDXW-1:0]    srch_index,
  input logic [ENTRIES-1:0] srch_vector
);

  localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

  // R7: a request enters the flag stage on the next edge.
  p_req_to_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srch_req |=> s1_vld);

  // R7: the flag stage completes on the following edge, and only then.
  p_stage_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> srch_done);

  p_no_spurious_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !srch_done);

  // R5: the reported index is a set bit of the vector and no lower bit is set.
  p_index_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> (srch_vector[srch_index] &&
                  ((srch_vector & ((ONE << srch_index) - ONE)) == '0)));

  // R5: multiple-hit flag agrees with the vector population.
  p_multi_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (srch_multi == ($countones(srch_vector) > 1)));

  // R6: a miss reports zeros everywhere.
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_hit) |-> (srch_index == '0 && !srch_multi && srch_vector == '0));

  // R10: results hold outside completion cycles.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_done |-> ($stable(srch_index) && $stable(srch_vector) &&
                    $stable(srch_hit) && $stable(srch_multi)));

endmodule

bind masked_cam_search masked_cam_search_chk #(.ENTRIES(ENTRIES), .IDXW(IDXW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .srch_req    (srch_req),
  .s1_vld      (s1_vld),
  .srch_done   (srch_done),
  .srch_hit    (srch_hit),
  .srch_multi  (srch_multi),
  .srch_index  (srch_index),
  .srch_vector (srch_vector)
);

// File: tb/test_masked_cam_search.sv
`timescale 1ns/1ps
module test_masked_cam_search;

  localparam int N = 64;
  localparam int W = 32;
  localparam int IW = 6;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic          wr_valid;
  logic          cmp_load;
  logic [W-1:0]  cmp_value;
  logic          mask_load;
  logic [W-1:0]  mask_value;
  logic          srch_req;
  logic          srch_done;
  logic          srch_hit;
  logic          srch_multi;
  logic [IW-1:0] srch_index;
  logic [N-1:0]  srch_vector;

  masked_cam_search #(.ENTRIES(N), .WIDTH(W)) i_masked_cam_search (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_valid(wr_valid),
    .cmp_load(cmp_load), .cmp_value(cmp_value),
    .mask_load(mask_load), .mask_value(mask_value),
    .srch_req(srch_req), .srch_done(srch_done), .srch_hit(srch_hit),
    .srch_multi(srch_multi), .srch_index(srch_index), .srch_vector(srch_vector)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;
  bit mon_on   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench reference state, derived from the requirements.
  logic [W-1:0] m_data [N];
  bit           m_vld  [N];
  logic [W-1:0] m_key;
  logic [W-1:0] m_ign;

  typedef struct {
    bit           hit;
    bit           multi;
    int           idx;
    logic [N-1:0] vec;
    int           cyc;
    string        tag;
  } exp_t;

  exp_t sbq[$];

  logic          last_hit, last_multi;
  logic [IW-1:0] last_idx;
  logic [N-1:0]  last_vec;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; a search pushes its expected result.
  task automatic step(input bit req, input bit cl, input logic [W-1:0] cv,
                      input bit ml, input logic [W-1:0] mv,
                      input bit we, input int wi, input logic [W-1:0] wd,
                      input bit wv, input string tag);
    @(negedge clk);
    srch_req = req; cmp_load = cl; cmp_value = cv; mask_load = ml; mask_value = mv;
    wr_en = we; wr_idx = IW'(wi); wr_data = wd; wr_valid = wv;
    if (req) begin
      exp_t e;
      logic [W-1:0] k, g;
      int cnt;
      k = cl ? cv : m_key;
      g = ml ? mv : m_ign;
      e.vec = '0; e.idx = 0; cnt = 0;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_vld[i] && (((m_data[i] ^ k) & ~g) == '0)) begin
          e.vec[i] = 1'b1; e.idx = i; cnt++;
        end
      end
      e.hit = (cnt > 0); e.multi = (cnt > 1);
      e.cyc = cyc + 2; e.tag = tag;
      sbq.push_back(e);
    end
    if (cl) m_key = cv;
    if (ml) m_ign = mv;
    if (we) begin m_data[wi] = wd; m_vld[wi] = wv; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, 0, 0, '0, 0, "-");
  endtask

  task automatic wr(input int i, input logic [W-1:0] d, input bit v);
    step(0, 0, '0, 0, '0, 1, i, d, v, "-");
  endtask

  task automatic srch(input logic [W-1:0] k, input logic [W-1:0] g, input string tag);
    step(1, 1, k, 1, g, 0, 0, '0, 0, tag);
  endtask

  // Monitor: pops and compares on every done; checks holding otherwise.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (srch_done) begin
        if (sbq.size() == 0) begin
          chk(0, "R7", "done without request", N'(srch_done), '0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(cyc == e.cyc, {e.tag, "/R7"}, "done cycle", N'(cyc), N'(e.cyc));
          chk(srch_hit == e.hit, e.tag, "hit", N'(srch_hit), N'(e.hit));
          chk(srch_multi == e.multi, {e.tag, "/R5"}, "multi", N'(srch_multi), N'(e.multi));
          chk(srch_index == IW'(e.idx), {e.tag, "/R5"}, "index", N'(srch_index), N'(e.idx));
          chk(srch_vector == e.vec, e.tag, "vector", srch_vector, e.vec);
        end
        last_hit = srch_hit; last_multi = srch_multi;
        last_idx = srch_index; last_vec = srch_vector;
      end else begin
        chk(srch_vector == last_vec && srch_index == last_idx &&
            srch_hit == last_hit && srch_multi == last_multi,
            "R10", "held results", srch_vector, last_vec);
        if (sbq.size() > 0 && cyc > sbq[0].cyc)
          chk(0, "R7", "missing done", N'(cyc), N'(sbq[0].cyc));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    srch_req = 0; cmp_load = 0; cmp_value = '0; mask_load = 0; mask_value = '0;
    wr_en = 0; wr_idx = '0; wr_data = '0; wr_valid = 0;
    m_key = '0; m_ign = '0;
    for (int i = 0; i < N; i++) begin m_data[i] = '0; m_vld[i] = 0; end
    last_hit = 0; last_multi = 0; last_idx = '0; last_vec = '0;

    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset.
    chk(srch_done == 0 && srch_hit == 0 && srch_multi == 0, "R1", "flags in reset",
        N'({srch_done, srch_hit, srch_multi}), '0);
    chk(srch_index == '0 && srch_vector == '0, "R1", "index/vector in reset",
        srch_vector, '0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1;

    // R1: every entry invalid after reset, even with all bits ignored.
    srch(32'h0, 32'hFFFF_FFFF, "R1");
    idle(2);

    wr(5,  32'hDEAD_BEEF, 1);
    wr(9,  32'h1234_5678, 1);
    wr(20, 32'hDEAD_0000, 1);
    wr(63, 32'hCAFE_F00D, 1);
    wr(0,  32'h0000_BEEF, 1);

    srch(32'hDEAD_BEEF, 32'h0, "R2");           // single exact hit at 5
    srch(32'h1234_5678, 32'h0, "R2");           // back-to-back, hit at 9
    srch(32'hCAFE_F00D, 32'h0, "R5");           // highest index alone
    srch(32'h7777_BEEF, 32'hFFFF_0000, "R3");   // low half key: 0 and 5
    srch(32'hDEAD_1111, 32'h0000_FFFF, "R5");   // high half key: 5 and 20
    srch(32'h0, 32'hFFFF_FFFF, "R3");           // all valid entries
    srch(32'h1111_1111, 32'h0, "R6");           // no match
    idle(3);

    // R4: invalidate entry 5, then the exact key misses.
    wr(5, 32'hDEAD_BEEF, 0);
    srch(32'hDEAD_BEEF, 32'h0, "R4");
    idle(3);

    // R8: overwrite 63 in the same cycle as a search for its old word.
    step(1, 1, 32'hCAFE_F00D, 1, 32'h0, 1, 63, 32'h0000_0001, 1, "R8");
    srch(32'hCAFE_F00D, 32'h0, "R8");            // new contents now seen
    // R8: validate an entry in the same cycle as a search that would match it.
    step(1, 1, 32'hABCD_0000, 1, 32'h0, 1, 30, 32'hABCD_0000, 1, "R8");
    srch(32'hABCD_0000, 32'h0, "R8");
    idle(3);

    // R9: loaded key/mask persist for searches that load nothing.
    step(0, 1, 32'h1234_5678, 1, 32'h0, 0, 0, '0, 0, "-");
    step(1, 0, '0, 0, '0, 0, 0, '0, 0, "R9");
    step(1, 0, '0, 1, 32'hFFFF_FFFF, 0, 0, '0, 0, "R9");  // mask-only load
    step(1, 1, 32'h0000_0001, 0, '0, 0, 0, '0, 0, "R9");  // key-only load, mask kept
    step(1, 0, '0, 1, 32'h0, 0, 0, '0, 0, "R9");          // exact on 0x1 -> entry 63
    idle(6);

    chk(sbq.size() == 0, "R7", "pending results", N'(sbq.size()), '0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule